// File: doc/BRIEF.md
# Embedded Operation Status Byte Generator

This block forms the byte that a flash-style memory returns on a read while an embedded program or erase is running, while sectors are being collected for erase, or while an erase is suspended. Outside those modes it passes the array data through. The status byte carries five signals. One is a polling bit that reads as the complement of the programmed data's top bit. Two are toggle bits that invert once per completed read cycle. One is a bit that flags an exceeded time limit. The last separates the sector-collection window from the running erase.

The surrounding command logic supplies the current operation mode, the mask of sectors chosen for erase, the byte being programmed and a timeout flag. The array supplies the stored byte at the read address. A read cycle counts as completed on the falling edge of the read strobe, sampled by the block clock. The result is registered: the output reflects the inputs present at the previous clock edge.

Top module: `sts_gen`

## Requirements
- R1: While reset is high, and on the first edge with reset high, the output is 0x00. Both toggle registers clear to 0.
- R2: Mode code 0 (array), and the unused codes 6 and 7, return the array byte unchanged.
- R3: Mode codes 1 (program) and 5 (program during erase suspend) return bit 7 as the inverse of bit 7 of the program byte, and bits 4 to 0 as 0.
- R4: The bit-6 toggle register inverts on each falling edge of the read strobe seen while the mode is 1, 2, 3 or 5, and holds in every other mode. Bit 6 shows it in modes 1, 2, 3 and 5.
- R5: In modes 1, 2, 3 and 5, bit 5 equals the timeout flag, and toggling continues while it is 1.
- R6: Mode codes 2 (erase sector-collection window) and 3 (erase running) return bit 7 as 0, bits 4, 1 and 0 as 0, and bit 3 as 0 in mode 2 and 1 in mode 3.
- R7: The sector of a read is the top log2(NUM_SECT) address bits, and mask bit i selects sector i. The bit-2 toggle register inverts on each strobe falling edge in modes 2, 3 or 4 whose read address falls in a selected sector. In modes 2 and 3, bit 2 shows that register for a selected sector and 0 otherwise.
- R8: Mode code 4 (erase suspended) returns 0x80 with bit 2 set to the bit-2 toggle register on a read of a selected sector. Bit 6 does not toggle. On any other sector it returns the array byte.
- R9: The output is registered. An input change appears at the output only after the next clock edge. A toggle advanced by a strobe fall appears one edge after the edge that sees the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe | input | 1 | Read strobe; a high-to-low change ends a read cycle |
| rd_addr | input | ADDR_W | Read address; the top bits select the sector |
| op_mode | input | 3 | Operation mode code (0 array, 1 program, 2 erase window, 3 erase running, 4 suspended, 5 suspended program) |
| sect_mask | input | NUM_SECT | Sectors selected for erase, one bit per sector |
| prog_byte | input | 8 | Byte being programmed |
| time_over | input | 1 | Embedded operation exceeded its time limit |
| array_byte | input | 8 | Stored byte at the read address |
| rd_data | output | 8 | Registered read value |

## Verification
The strobe fall that advances a toggle register can arrive on the same edge as a change of operation mode. The toggle then follows the mode sampled on that edge, not the one before. The bench provokes this by dropping the strobe in the same cycle that it moves program mode to array mode, and in the same cycle that it moves erase-running mode to suspend mode. It then reads the held toggle values back through later status bytes: bit 6 must be unchanged after the first case. After the second case bit 2 must have advanced and bit 6 must not have.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [2:0] {
    MD_ARRAY     = 3'd0,
    MD_PROG      = 3'd1,
    MD_ERS_WIN   = 3'd2,
    MD_ERS_RUN   = 3'd3,
    MD_SUSP      = 3'd4,
    MD_SUSP_PROG = 3'd5
  } op_mode_e;

  function automatic logic mode_is_prog(input logic [2:0] m);
    return (m == MD_PROG) || (m == MD_SUSP_PROG);
  endfunction

  function automatic logic mode_is_erase(input logic [2:0] m);
    return (m == MD_ERS_WIN) || (m == MD_ERS_RUN);
  endfunction

  // modes in which the bit-6 toggle advances
  function automatic logic mode_busy(input logic [2:0] m);
    return mode_is_prog(m) || mode_is_erase(m);
  endfunction

  // modes in which the bit-2 toggle may advance
  function automatic logic mode_sect_track(input logic [2:0] m);
    return mode_is_erase(m) || (m == MD_SUSP);
  endfunction
endpackage

// File: rtl/sts_sector_hit.sv
module sts_sector_hit #(
  parameter int ADDR_W   = 19,
  parameter int NUM_SECT = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_SECT-1:0] mask,
  output logic                hit
);
  localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  logic [SECT_W-1:0]   sect_idx;
  logic [NUM_SECT-1:0] match;

  assign sect_idx = addr[ADDR_W-1 -: SECT_W];

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    assign match[i] = mask[i] && (sect_idx == SECT_W'(i));
  end

  assign hit = |match;
endmodule

// File: rtl/sts_fall_det.sv
module sts_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic fall
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign fall = strobe_q && !strobe;
endmodule

// File: rtl/sts_toggle.sv
module sts_toggle (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/sts_gen.sv
module sts_gen #(
  parameter int ADDR_W   = 19,
  parameter int NUM_SECT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_strobe,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [2:0]          op_mode,
  input  logic [NUM_SECT-1:0] sect_mask,
  input  logic [7:0]          prog_byte,
  input  logic                time_over,
  input  logic [7:0]          array_byte,
  output logic [7:0]          rd_data
);
  import sts_pkg::*;

  logic fall;
  logic sect_hit;
  logic tgl6, tgl2;
  logic adv6, adv2;
  logic [7:0] nxt;

  sts_fall_det u_fall (
    .clk(clk), .rst(rst), .strobe(rd_strobe), .fall(fall)
  );

  sts_sector_hit #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_hit (
    .addr(rd_addr), .mask(sect_mask), .hit(sect_hit)
  );

  assign adv6 = fall && mode_busy(op_mode);
  assign adv2 = fall && mode_sect_track(op_mode) && sect_hit;

  sts_toggle u_tgl6 (.clk(clk), .rst(rst), .adv(adv6), .q(tgl6));
  sts_toggle u_tgl2 (.clk(clk), .rst(rst), .adv(adv2), .q(tgl2));

  always_comb begin
    nxt = 8'h00;
    unique case (op_mode)
      MD_PROG, MD_SUSP_PROG: begin
        nxt[7] = ~prog_byte[7];
        nxt[6] = tgl6;
        nxt[5] = time_over;
      end
      MD_ERS_WIN, MD_ERS_RUN: begin
        nxt[6] = tgl6;
        nxt[5] = time_over;
        nxt[3] = (op_mode == MD_ERS_RUN);
        nxt[2] = sect_hit && tgl2;
      end
      MD_SUSP: begin
        if (sect_hit) begin
          nxt[7] = 1'b1;
          nxt[2] = tgl2;
        end else begin
          nxt = array_byte;
        end
      end
      default: nxt = array_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= nxt;
  end
endmodule

// File: rtl/sts_gen_chk.sv
module sts_gen_chk #(
  parameter int ADDR_W   = 19,
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_strobe,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [2:0]          op_mode,
  input logic [NUM_SECT-1:0] sect_mask,
  input logic [7:0]          prog_byte,
  input logic                time_over,
  input logic [7:0]          array_byte,
  input logic [7:0]          rd_data
);
  import sts_pkg::*;

  logic [1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= 2'd0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (rst)
    (run_cnt != 2'd0) && ($past(op_mode) == 3'd0) |-> rd_data == $past(array_byte)); // R2

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
    (run_cnt != 2'd0) && mode_is_prog($past(op_mode))
    |-> (rd_data[7] == ~$past(prog_byte[7])) && (rd_data[4:0] == 5'd0)); // R3

  AST_BUSY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    (run_cnt != 2'd0) && mode_busy($past(op_mode)) |-> rd_data[5] == $past(time_over)); // R5

  AST_ERASE_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (run_cnt != 2'd0) && mode_is_erase($past(op_mode))
    |-> !rd_data[7] && (rd_data[3] == ($past(op_mode) == 3'd3)) && (rd_data[1:0] == 2'd0)); // R6

  AST_B6_FLIP: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 2'd3) && mode_busy($past(op_mode)) && mode_busy($past(op_mode, 2))
    |-> (rd_data[6] != $past(rd_data[6])) ==
        ($past(rd_strobe, 3) && !$past(rd_strobe, 2))); // R4
endmodule

bind sts_gen sts_gen_chk #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
  .op_mode(op_mode), .sect_mask(sect_mask), .prog_byte(prog_byte),
  .time_over(time_over), .array_byte(array_byte), .rd_data(rd_data)
);

// File: tb/sim_sts_gen.sv
module sim_sts_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;
  localparam int NUM_SECT   = 8;
  localparam int NVEC       = 19;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                rd_strobe = 1'b0;
  logic [ADDR_W-1:0]   rd_addr = '0;
  logic [2:0]          op_mode = 3'd0;
  logic [NUM_SECT-1:0] sect_mask = '0;
  logic [7:0]          prog_byte = 8'h00;
  logic                time_over = 1'b0;
  logic [7:0]          array_byte = 8'h00;
  logic [7:0]          rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sts_gen #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) u0 (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .op_mode(op_mode), .sect_mask(sect_mask), .prog_byte(prog_byte),
    .time_over(time_over), .array_byte(array_byte), .rd_data(rd_data)
  );

  // req[4] mode[3] sect[3] mask[8] prog[8] tmo[1] arr[8] rd[1] exp[8]
  localparam logic [43:0] VEC [NVEC] = '{
    {4'd2, 3'd0, 3'd0, 8'h00, 8'h00, 1'b0, 8'hA5, 1'b1, 8'hA5}, // R2 array pass
    {4'd3, 3'd1, 3'd0, 8'h00, 8'h80, 1'b0, 8'h00, 1'b1, 8'h40}, // R3 R4
    {4'd3, 3'd1, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'h80}, // R3 R4
    {4'd4, 3'd1, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h80}, // R4 no read
    {4'd5, 3'd1, 3'd0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 8'hE0}, // R5
    {4'd2, 3'd0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h3C, 1'b1, 8'h3C}, // R2
    {4'd6, 3'd2, 3'd2, 8'h04, 8'h00, 1'b0, 8'h00, 1'b1, 8'h04}, // R6 R7 window
    {4'd6, 3'd3, 3'd2, 8'h04, 8'h00, 1'b0, 8'h00, 1'b1, 8'h48}, // R6 R7 running
    {4'd7, 3'd3, 3'd5, 8'h04, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08}, // R7 unselected
    {4'd5, 3'd3, 3'd2, 8'h04, 8'h00, 1'b1, 8'h00, 1'b1, 8'h6C}, // R5 R7
    {4'd8, 3'd4, 3'd2, 8'h04, 8'h00, 1'b0, 8'h77, 1'b1, 8'h80}, // R8 selected
    {4'd8, 3'd4, 3'd2, 8'h04, 8'h00, 1'b0, 8'h77, 1'b1, 8'h84}, // R8
    {4'd8, 3'd4, 3'd6, 8'h04, 8'h00, 1'b0, 8'h5A, 1'b1, 8'h5A}, // R8 other sector
    {4'd3, 3'd5, 3'd6, 8'h04, 8'h7F, 1'b0, 8'h00, 1'b1, 8'h80}, // R3 suspended program
    {4'd3, 3'd5, 3'd6, 8'h04, 8'hFF, 1'b0, 8'h00, 1'b1, 8'h40}, // R3 R4
    {4'd2, 3'd6, 3'd0, 8'h00, 8'h00, 1'b0, 8'h99, 1'b1, 8'h99}, // R2 unused code
    {4'd7, 3'd4, 3'd2, 8'h04, 8'h00, 1'b0, 8'h00, 1'b0, 8'h84}, // R7 held
    {4'd7, 3'd3, 3'd7, 8'h80, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08}, // R7 top sector
    {4'd7, 3'd2, 3'd0, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 8'h44}  // R7 all selected
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic set_in(input logic [2:0] m, input logic [2:0] s,
                        input logic [7:0] mk, input logic [7:0] pd,
                        input logic to, input logic [7:0] ad);
    op_mode = m;
    rd_addr = {s, 16'h1234};
    sect_mask = mk;
    prog_byte = pd;
    time_over = to;
    array_byte = ad;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 8'h00, "R1", rd_data, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [43:0] v;
      v = VEC[i];
      set_in(v[39:37], v[36:34], v[33:26], v[25:18], v[17], v[16:9]);
      rd_strobe = v[8];
      @(negedge clk);
      rd_strobe = 1'b0;
      repeat (2) @(negedge clk);
      check(rd_data == v[7:0], $sformatf("R%0d vec%0d", v[43:40], i), rd_data, v[7:0]);
    end

    // R1: reset clears output and both toggles
    rst = 1'b1;
    @(negedge clk);
    check(rd_data == 8'h00, "R1 in reset", rd_data, 8'h00);
    rst = 1'b0;
    set_in(3'd1, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00);
    @(negedge clk);
    check(rd_data == 8'h80, "R1 tgl6 cleared", rd_data, 8'h80);
    set_in(3'd4, 3'd2, 8'h04, 8'h00, 1'b0, 8'h00);
    @(negedge clk);
    check(rd_data == 8'h80, "R1 tgl2 cleared", rd_data, 8'h80);

    // R4: strobe falls on the edge where mode moves program -> array
    set_in(3'd1, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    op_mode = 3'd0;
    @(negedge clk);
    op_mode = 3'd1;
    repeat (2) @(negedge clk);
    check(rd_data == 8'h80, "R4 fall with mode exit", rd_data, 8'h80);

    // R7 R4: strobe falls on the edge where mode moves running -> suspended
    set_in(3'd3, 3'd2, 8'h04, 8'h00, 1'b0, 8'h00);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    op_mode = 3'd4;
    repeat (2) @(negedge clk);
    check(rd_data == 8'h84, "R7 fall into suspend", rd_data, 8'h84);
    op_mode = 3'd3;
    @(negedge clk);
    check(rd_data == 8'h0C, "R4 tgl6 held into suspend", rd_data, 8'h0C);

    // R9: output registered, no combinational path
    set_in(3'd0, 3'd0, 8'h00, 8'h00, 1'b0, 8'h11);
    @(negedge clk);
    array_byte = 8'h22;
    #1;
    check(rd_data == 8'h11, "R9 before edge", rd_data, 8'h11);
    @(negedge clk);
    check(rd_data == 8'h22, "R9 after edge", rd_data, 8'h22);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule